// File: doc/BRIEF.md
# Parallel Readout Port for Eight 18-Bit Conversion Results

This block is the device side of a 16-bit parallel read port for a converter that produces eight 18-bit results per conversion. A host paces the transfer with an active-low chip select and an active-low read strobe. Each result leaves the port in two bus words, the upper sixteen bits first and then the two least significant bits. Channels go out in ascending order, so sixteen strobes drain one full set. A first-word flag marks the words that belong to channel 1, so the host can realign if it loses count.

The host pins are asynchronous to the system clock. Each one passes through a synchronizer, and the port reacts on the resulting clock edges. The results vector is copied into a holding register when the conversion busy signal falls. That same edge sends the read pointer back to channel 1. Reads made while busy is high therefore return the previous set. The three-state behaviour is given as separate enable outputs for the data bus and for the flag. Chip select can be held low with read alone pacing the transfer, or chip select and read can be wired together.

Top module: `par_readout`

## Requirements
- R1: During reset, bus_oe_o, first_oe_o, first_o and bus_o are all zero.
- R2: bus_oe_o is high only while cs_n_i and rd_n_i are both low, as seen three clock edges after the pins. A raised chip select drops it.
- R3: After busy_i falls, the first strobe presents channel 1 bits [17:2] on bus_o[15:0]. The second strobe presents channel 1 bits [1:0] on bus_o[1:0], with bus_o[15:2] at zero.
- R4: Consecutive strobes return the sixteen words in ascending channel order, upper half before lower half. The 16th strobe presents channel 8 bits [1:0]. Channel k (k = 1 to 8) sits at results_i[(k-1)*18 +: 18].
- R5: A strobe is the moment both cs_n_i and rd_n_i become low. Read pulses with chip select tied low and combined chip-select-and-read pulses each advance one word. Read pulses while chip select is high leave bus_o and the pointer unchanged.
- R6: results_i is copied only when busy_i falls. While busy_i is high, reads return the previous set.
- R7: first_o goes high on the strobe that presents either word of channel 1. It goes low on the strobe that presents any later word.
- R8: first_oe_o is high exactly while cs_n_i is low, with the same three-edge lag.
- R9: The strobe after the 16th wraps to channel 1 upper bits.
- R10: A busy_i falling edge in the middle of a transfer sends the next strobe back to channel 1 upper bits of the new set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the host strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| busy_i | input | 1 | Conversion in progress; falling edge captures results |
| results_i | input | 144 | Eight 18-bit results, channel 1 in the lowest bits |
| bus_o | output | 16 | Parallel data word |
| bus_oe_o | output | 1 | Drive enable for bus_o |
| first_o | output | 1 | High while a channel 1 word is presented |
| first_oe_o | output | 1 | Drive enable for first_o |

## Verification
The assertions assume that every host pin holds each level for at least three clock cycles, so no pulse can be lost in the synchronizer. They also assume that results_i is stable in the cycles around the busy falling edge. The stimulus changes pins only on falling clock edges and holds every phase for five cycles. results_i is loaded before busy_i is raised and is left unchanged until busy_i has been low for six cycles. Strobes are never issued in the same window as a busy edge, because the port gives priority to the pointer reset when both happen together.

// File: rtl/par_readout_pkg.sv
package par_readout_pkg;

    // which half of an 18-bit result the read pointer addresses
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_e;

    // host pin positions inside the synchronizer vector
    localparam int unsigned PIN_RD   = 0;
    localparam int unsigned PIN_CS   = 1;
    localparam int unsigned PIN_BUSY = 2;
    localparam int unsigned PIN_CNT  = 3;

endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
    parameter int unsigned           WIDTH     = 1,
    parameter int unsigned           STAGES    = 2,
    parameter logic [WIDTH-1:0]      RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pr_word_sel.sv
module pr_word_sel
    import par_readout_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned RES_W  = 18,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned PTR_W  = 4
) (
    input  logic [NUM_CH*RES_W-1:0] snap_i,
    input  logic [PTR_W-1:0]        ptr_i,
    output logic [BUS_W-1:0]        word_o,
    output logic                    is_first_o
);

    localparam int unsigned LO_W = RES_W - BUS_W;
    localparam int unsigned CH_W = PTR_W - 1;

    logic [RES_W-1:0] chan [NUM_CH];
    logic [CH_W-1:0]  ch_idx;
    half_e            half;
    logic [RES_W-1:0] cur;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            assign chan[c] = snap_i[c*RES_W +: RES_W];
        end
    endgenerate

    always_comb begin
        ch_idx     = ptr_i[PTR_W-1:1];
        half       = half_e'(ptr_i[0]);
        cur        = chan[ch_idx];
        is_first_o = (ch_idx == '0);
        if (half == HALF_UPPER) word_o = cur[RES_W-1 -: BUS_W];
        else                    word_o = {{(BUS_W-LO_W){1'b0}}, cur[LO_W-1:0]};
    end

endmodule

// File: rtl/par_readout.sv
module par_readout
    import par_readout_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned RES_W       = 18,
    parameter int unsigned BUS_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n_i,
    input  logic                    rd_n_i,
    input  logic                    busy_i,
    input  logic [NUM_CH*RES_W-1:0] results_i,
    output logic [BUS_W-1:0]        bus_o,
    output logic                    bus_oe_o,
    output logic                    first_o,
    output logic                    first_oe_o
);

    localparam int unsigned WORDS  = 2 * NUM_CH;
    localparam int unsigned PTR_W  = $clog2(WORDS);
    localparam int unsigned FLAT_W = NUM_CH * RES_W;
    localparam logic [PTR_W-1:0]   LAST_PTR = PTR_W'(WORDS - 1);
    localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'(3'b011);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [FLAT_W-1:0] snap;
        logic [BUS_W-1:0]  data;
        logic              oe;
        logic              first;
        logic              first_oe;
        logic              acc_prev;
        logic              busy_prev;
    } state_t;

    state_t state_d, state_q;

    logic [PIN_CNT-1:0] pins_async, pins_sync;
    logic               cs_s, rd_s, busy_s;
    logic               access, strobe, busy_fall;
    logic [BUS_W-1:0]   sel_word;
    logic               sel_first;

    assign pins_async = {busy_i, cs_n_i, rd_n_i};

    pr_sync #(
        .WIDTH     (PIN_CNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_async),
        .sync_o  (pins_sync)
    );

    assign rd_s   = pins_sync[PIN_RD];
    assign cs_s   = pins_sync[PIN_CS];
    assign busy_s = pins_sync[PIN_BUSY];

    pr_word_sel #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .BUS_W  (BUS_W),
        .PTR_W  (PTR_W)
    ) u_sel (
        .snap_i     (state_q.snap),
        .ptr_i      (state_q.ptr),
        .word_o     (sel_word),
        .is_first_o (sel_first)
    );

    always_comb begin
        access    = !cs_s && !rd_s;
        strobe    = access && !state_q.acc_prev;
        busy_fall = !busy_s && state_q.busy_prev;

        state_d           = state_q;
        state_d.acc_prev  = access;
        state_d.busy_prev = busy_s;
        state_d.oe        = access;
        state_d.first_oe  = !cs_s;

        if (busy_fall) begin
            // new set captured; pointer back to channel 1 upper half
            state_d.snap = results_i;
            state_d.ptr  = '0;
        end else if (strobe) begin
            state_d.data  = sel_word;
            state_d.first = sel_first;
            state_d.ptr   = (state_q.ptr == LAST_PTR) ? '0 : state_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_o      = state_q.data;
    assign bus_oe_o   = state_q.oe;
    assign first_o    = state_q.first;
    assign first_oe_o = state_q.first_oe;

endmodule

// File: rtl/pr_checker.sv
module pr_checker #(
    parameter int unsigned BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_i,
    input logic             rd_n_i,
    input logic [BUS_W-1:0] bus_o,
    input logic             bus_oe_o,
    input logic             first_o,
    input logic             first_oe_o
);

    // cycles since reset, saturating, so $past never reaches before reset
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_BUS_OE_FOLLOWS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (bus_oe_o == (!$past(cs_n_i, 3) && !$past(rd_n_i, 3)))); // R2

    AST_FLAG_OE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (first_oe_o == !$past(cs_n_i, 3))); // R8

    AST_WORD_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_o) |-> $rose(bus_oe_o)); // R5

    AST_FLAG_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(first_o) |-> $rose(bus_oe_o)); // R7

endmodule

bind par_readout pr_checker #(.BUS_W(BUS_W)) u_pr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o),
    .first_o    (first_o),
    .first_oe_o (first_oe_o)
);

// File: tb/par_readout_bench.sv
module par_readout_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 8;
    localparam int RES_W      = 18;
    localparam int BUS_W      = 16;
    localparam int LO_W       = RES_W - BUS_W;
    localparam int WORDS      = 2 * NUM_CH;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cs_n = 1'b1;
    logic                    rd_n = 1'b1;
    logic                    busy = 1'b0;
    logic [NUM_CH*RES_W-1:0] results = '0;
    logic [BUS_W-1:0]        bus;
    logic                    bus_oe, first, first_oe;

    int checks = 0;
    int errors = 0;
    logic [RES_W-1:0] snap_tab [NUM_CH];

    always #(CLK_PERIOD/2) clk = ~clk;

    par_readout u_par_readout (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .rd_n_i     (rd_n),
        .busy_i     (busy),
        .results_i  (results),
        .bus_o      (bus),
        .bus_oe_o   (bus_oe),
        .first_o    (first),
        .first_oe_o (first_oe)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [RES_W-1:0] pat(input int p, input int ch);
        case (p)
            0:       return '1;
            1:       return '0;
            2:       return RES_W'(32'h20000 ^ ch);
            3:       return RES_W'(32'h1FFFF - ch * 3);
            default: return RES_W'(p * 40503 + ch * 9973 + 7);
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] exp_word(input int idx);
        logic [RES_W-1:0] r;
        r = snap_tab[idx / 2];
        if (idx % 2 == 0) return r[RES_W-1 -: BUS_W];
        return BUS_W'(r[LO_W-1:0]);
    endfunction

    task automatic load_results(input int p);
        for (int ch = 0; ch < NUM_CH; ch++) results[ch*RES_W +: RES_W] = pat(p, ch);
    endtask

    task automatic convert(input int p);
        load_results(p);
        busy = 1'b1;
        wait_cyc(6);
        busy = 1'b0;
        wait_cyc(6);
        for (int ch = 0; ch < NUM_CH; ch++) snap_tab[ch] = pat(p, ch);
    endtask

    task automatic strobe(input bit combined, input int idx, input string req);
        if (combined) cs_n = 1'b0;
        rd_n = 1'b0;
        wait_cyc(5);
        chk(req, "bus word", 32'(bus), 32'(exp_word(idx)));
        chk("R7", "first flag", 32'(first), (idx < 2) ? 32'd1 : 32'd0);
        chk("R2", "bus enable on", 32'(bus_oe), 32'd1);
        rd_n = 1'b1;
        if (combined) cs_n = 1'b1;
        wait_cyc(5);
        chk("R2", "bus enable off", 32'(bus_oe), 32'd0);
        if (combined) chk("R8", "flag enable off", 32'(first_oe), 32'd0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        wait_cyc(4);
        // R1: reset state
        chk("R1", "bus enable", 32'(bus_oe), 32'd0);
        chk("R1", "flag enable", 32'(first_oe), 32'd0);
        chk("R1", "bus", 32'(bus), 32'd0);
        chk("R1", "flag", 32'(first), 32'd0);
        rst_n = 1'b1;
        wait_cyc(6);

        // R3 R4: full sweeps, alternating pacing styles
        for (int p = 0; p < 6; p++) begin
            bit combined;
            combined = (p % 2) == 1;
            convert(p);
            if (!combined) begin
                cs_n = 1'b0;
                wait_cyc(5);
                chk("R8", "flag enable on", 32'(first_oe), 32'd1);
            end
            for (int i = 0; i < WORDS; i++)
                strobe(combined, i, (i < 2) ? "R3" : "R4");
            cs_n = 1'b1;
            wait_cyc(5);
        end

        // R9: the strobe after the 16th wraps to channel 1 upper
        strobe(1'b1, 0, "R9");

        // R5: read pulse with chip select high is ignored
        rd_n = 1'b0;
        wait_cyc(5);
        chk("R5", "enable with cs high", 32'(bus_oe), 32'd0);
        chk("R5", "bus held", 32'(bus), 32'(exp_word(0)));
        rd_n = 1'b1;
        wait_cyc(5);
        strobe(1'b1, 1, "R5");

        // R10: busy fall mid transfer restarts at channel 1
        strobe(1'b1, 2, "R4");
        strobe(1'b1, 3, "R4");
        convert(6);
        strobe(1'b1, 0, "R10");
        strobe(1'b1, 1, "R10");

        // R6: reads during busy return previous set
        load_results(7);
        busy = 1'b1;
        wait_cyc(6);
        for (int i = 2; i < 6; i++) strobe(1'b1, i, "R6");
        busy = 1'b0;
        wait_cyc(6);
        for (int ch = 0; ch < NUM_CH; ch++) snap_tab[ch] = pat(7, ch);
        strobe(1'b1, 0, "R6");
        strobe(1'b1, 1, "R6");

        summary();
        $finish;
    end

endmodule